// File: doc/BRIEF.md
# DDR2 Bank Command Timing Scheduler

This block sits between a memory controller's request logic and the command pins of a DDR2 device. It takes one request at a time (row open, column read, column write, or bank close), each aimed at one of eight banks. It turns each accepted request into the chip-select, row-strobe, column-strobe and write-enable levels, plus the bank and address fields, that the device expects. It keeps a record of which banks hold an open row. It runs per-bank countdowns that decide when a bank may next be closed or reopened, and shared countdowns that space column commands and row opens on the command bus.

Requests use a valid/ready handshake. Ready is worked out only from the internal state, the requested operation and the requested bank. A request that would break a spacing rule, or that does not fit the bank's open or closed state, is held back until it becomes legal. A column request with address bit 10 set also closes its bank without a separate close command. The close starts once the burst has drained, plus write recovery for writes, and the reopen limit is derived from that point.

Top module: `ddr2_cmd_sched`

## Requirements
- R1: After reset the command pins all sit high (deselect). An open request is ready for every bank. Read and write requests are not ready for any bank.
- R2: Request codes are 0 = open row, 1 = read, 2 = write, 3 = close. An accepted request appears on the pins one clock after the edge that accepted it, with chip-select low and {row, column, write} strobes as follows: open = {0,1,1}, read = {1,0,1}, write = {1,0,0}, close = {0,1,0}. The bank field is copied to the bank pins. The address is copied for open, read and write, and is zero for close. Every other cycle shows all four pins high.
- R3: A read or write request to a closed bank, or an open request to an open bank, is not ready and issues nothing while held.
- R4: After a read without auto-close, a close of the same bank is accepted no sooner than AL + BL/2 + max(tRTP,2) − 2 clocks later (3 at the defaults).
- R5: After a write without auto-close, a close of the same bank is accepted no sooner than WL + BL/2 + tWR clocks later, where WL = AL + CL − 1 (8 at the defaults).
- R6: After a close of an open bank, that bank accepts an open no sooner than tRP clocks later (3).
- R7: A read or write with address bit 10 set leaves its bank closed at once. The bank accepts an open no sooner than the R4 or R5 spacing plus tRP after the column command (6 after a read, 11 after a write at the defaults).
- R8: A read or write to a bank is accepted on the clock right after that bank's open command.
- R9: Column commands on the bus are spaced at least 2 clocks apart when of the same kind. A write follows a read by at least BL/2 + 2 clocks (4). A read follows a write by at least CL − 1 + BL/2 + tWTR clocks (6).
- R10: Two open commands, to any banks, are at least tRRD clocks apart (2).
- R11: A close request to a bank that is already closed is ready and issued, and the bank stays closed.
- R12: Ready does not depend on valid, and nothing is issued while valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_op | input | 2 | Request code (open, read, write, close) |
| req_bank | input | 3 | Target bank |
| req_addr | input | 14 | Row for open, column for read/write; bit 10 requests auto-close |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank pins |
| ddr_addr | output | 14 | Address pins |

## Verification
Each encoded command is due on the pins exactly one clock after its acceptance edge. The bench stamps every expected item with that cycle number, and the monitor compares the stamp against a free-running edge counter at the following falling edge. Spacing results (R4 to R10) are measured as the number of edges between the acceptance of a request and the acceptance of the next one, with the second request presented from the first falling edge after. The count therefore equals the minimum spacing exactly when the design neither stalls too long nor too little. Stall checks hold valid high for two cycles and rely on the monitor reporting any command that was not expected.

// File: rtl/ddr2_sched_pkg.sv
// Shared types and helpers for the DDR2 command scheduler.
// Assumes request codes are fixed by the request-side logic.
package ddr2_sched_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } sched_op_e;

    // Larger of two integers, used to derive spacing terms.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sched_countdown.sv
// Saturating down-counter used for every spacing rule.
// A load keeps the larger of the decremented value and the new value,
// so overlapping constraints never shorten one another.
// Assumes load_val is the wanted spacing minus one.
module sched_countdown #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt,
    output logic          zero
);
    logic [TW-1:0] dec;

    // Next value when no load occurs.
    always_comb begin
        dec = (cnt != '0) ? cnt - 1'b1 : '0;
    end

    // Counter register with max-merge on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val > dec) ? load_val : dec;
        end else begin
            cnt <= dec;
        end
    end

    assign zero = (cnt == '0);

    // R4: a running count keeps falling by one each clock when not reloaded.
    a_r4_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sched_bank_timer.sv
// State for one bank: open flag, close-eligibility count and reopen count.
// Assumes the top only strobes a do_* input when the request is legal.
module sched_bank_timer #(
    parameter int TW     = 4,
    parameter int RD2PRE = 3,
    parameter int WR2PRE = 8,
    parameter int TRP    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_rd,
    input  logic do_wr,
    input  logic do_pre,
    input  logic auto_pre,
    output logic is_open,
    output logic pre_ok,
    output logic act_ok
);
    localparam logic [TW-1:0] RD_L  = TW'(RD2PRE - 1);
    localparam logic [TW-1:0] WR_L  = TW'(WR2PRE - 1);
    localparam logic [TW-1:0] TRP_V = TW'(TRP);
    localparam logic [TW-1:0] TRP_L = TW'(TRP - 1);

    logic          cas_any;
    logic          pre_load;
    logic [TW-1:0] pre_val;
    logic [TW-1:0] pre_cnt;
    logic [TW-1:0] pre_dec;
    logic          pre_zero;
    logic          act_load;
    logic [TW-1:0] act_val;
    logic [TW-1:0] act_cnt;
    logic          act_zero;
    logic [TW-1:0] col_l;
    logic [TW-1:0] drain_l;

    assign cas_any = do_rd | do_wr;

    // Select the close spacing for this column command and the reopen load.
    always_comb begin
        col_l    = do_wr ? WR_L : RD_L;
        pre_dec  = (pre_cnt != '0) ? pre_cnt - 1'b1 : '0;
        drain_l  = (pre_dec > col_l) ? pre_dec : col_l;
        pre_load = cas_any & ~auto_pre;
        pre_val  = col_l;
        act_load = (cas_any & auto_pre) | (do_pre & is_open);
        act_val  = (cas_any & auto_pre) ? drain_l + TRP_V : TRP_L;
    end

    sched_countdown #(.TW(TW)) u_pre_cnt (
        .clk(clk), .rst_n(rst_n), .load(pre_load), .load_val(pre_val),
        .cnt(pre_cnt), .zero(pre_zero)
    );

    sched_countdown #(.TW(TW)) u_act_cnt (
        .clk(clk), .rst_n(rst_n), .load(act_load), .load_val(act_val),
        .cnt(act_cnt), .zero(act_zero)
    );

    // Open flag: set by activate, cleared by close or auto-close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
        end else if (do_act) begin
            is_open <= 1'b1;
        end else if (do_pre || (cas_any && auto_pre)) begin
            is_open <= 1'b0;
        end
    end

    assign pre_ok = pre_zero;
    assign act_ok = act_zero & ~is_open;

    // R3: row open only reaches a closed bank.
    a_r3_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> !is_open);
    // R3: column commands only reach an open bank.
    a_r3_cas_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> is_open);
    // R7: auto-close leaves the bank closed on the next clock.
    a_r7_auto_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && auto_pre) |=> !is_open);
    // R6: a close of an open bank leaves it closed afterwards.
    a_r6_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pre && is_open) |=> !is_open);

endmodule

// File: rtl/sched_bus_gap.sv
// Bus-wide spacing: column-to-column per kind and activate-to-activate.
// Assumes at most one command is issued per clock.
module sched_bus_gap #(
    parameter int TW    = 4,
    parameter int CCD   = 2,
    parameter int RD2WR = 4,
    parameter int WR2RD = 6,
    parameter int TRRD  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_act,
    input  logic is_rd,
    input  logic is_wr,
    output logic rd_ok,
    output logic wr_ok,
    output logic rrd_ok
);
    logic [TW-1:0] rd_val;
    logic [TW-1:0] wr_val;
    logic [TW-1:0] rd_cnt;
    logic [TW-1:0] wr_cnt;
    logic [TW-1:0] rrd_cnt;

    // Gap to the next read and next write, depending on the kind just sent.
    always_comb begin
        rd_val = is_rd ? TW'(CCD - 1) : TW'(WR2RD - 1);
        wr_val = is_wr ? TW'(CCD - 1) : TW'(RD2WR - 1);
    end

    sched_countdown #(.TW(TW)) u_rd_gap (
        .clk(clk), .rst_n(rst_n), .load(is_rd | is_wr), .load_val(rd_val),
        .cnt(rd_cnt), .zero(rd_ok)
    );

    sched_countdown #(.TW(TW)) u_wr_gap (
        .clk(clk), .rst_n(rst_n), .load(is_rd | is_wr), .load_val(wr_val),
        .cnt(wr_cnt), .zero(wr_ok)
    );

    sched_countdown #(.TW(TW)) u_rrd_gap (
        .clk(clk), .rst_n(rst_n), .load(is_act), .load_val(TW'(TRRD - 1)),
        .cnt(rrd_cnt), .zero(rrd_ok)
    );

    // R9: a read blocks another read on the very next clock.
    a_r9_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> !rd_ok);
    // R9: a write blocks another write on the very next clock.
    a_r9_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> !wr_ok);
    // R10: an activate blocks another activate on the next clock.
    a_r10_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && TRRD > 1) |=> !rrd_ok);

endmodule

// File: rtl/sched_cmd_enc.sv
// Registers the pin encoding of an accepted request.
// Assumes fire is high for exactly one clock per accepted request.
module sched_cmd_enc
    import ddr2_sched_pkg::*;
#(
    parameter int BA_W = 3,
    parameter int AW   = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  sched_op_e       op,
    input  logic [BA_W-1:0] bank,
    input  logic [AW-1:0]   addr,
    output logic            cs_n,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic [BA_W-1:0] ba,
    output logic [AW-1:0]   a
);
    logic [2:0] strobes;

    // Strobe levels {ras,cas,we} for each request code.
    always_comb begin
        case (op)
            OP_ACT:  strobes = 3'b011;
            OP_RD:   strobes = 3'b101;
            OP_WR:   strobes = 3'b100;
            default: strobes = 3'b010;
        endcase
    end

    // Pin register: encoded command on accept, deselect otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            cs_n  <= 1'b1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ba    <= '0;
            a     <= '0;
        end else begin
            cs_n  <= 1'b0;
            {ras_n, cas_n, we_n} <= strobes;
            ba    <= bank;
            a     <= (op == OP_PRE) ? '0 : addr;
        end
    end

    // R2: an accepted request selects the device on the next clock.
    a_r2_select_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !cs_n);
    // R2: a cycle without acceptance yields deselect on the next clock.
    a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (cs_n && ras_n && cas_n && we_n));

endmodule

// File: rtl/ddr2_cmd_sched.sv
// DDR2 bank command scheduler top. Accepts one request per clock over a
// valid/ready handshake, gates it on bank state and spacing rules, and
// drives the registered command pins. Assumes one rank and that refresh
// and the data path are handled elsewhere.
module ddr2_cmd_sched
    import ddr2_sched_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int AW    = 14,
    parameter int AP_BIT = 10,
    parameter int BL    = 4,
    parameter int AL    = 1,
    parameter int CL    = 3,
    parameter int TWR   = 3,
    parameter int TRTP  = 2,
    parameter int TWTR  = 2,
    parameter int TRP   = 3,
    parameter int TRRD  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [$clog2(NBANK)-1:0] req_bank,
    input  logic [AW-1:0]            req_addr,
    output logic                     ddr_cs_n,
    output logic                     ddr_ras_n,
    output logic                     ddr_cas_n,
    output logic                     ddr_we_n,
    output logic [$clog2(NBANK)-1:0] ddr_ba,
    output logic [AW-1:0]            ddr_addr
);
    localparam int BA_W   = $clog2(NBANK);
    localparam int HALF   = BL / 2;
    localparam int WL     = AL + CL - 1;
    localparam int RD2PRE = AL + HALF + imax(TRTP, 2) - 2;
    localparam int WR2PRE = WL + HALF + TWR;
    localparam int RD2WR  = HALF + 2;
    localparam int WR2RD  = CL - 1 + HALF + TWTR;
    localparam int CCD    = 2;
    localparam int TW     = $clog2(imax(WR2PRE, WR2RD) + TRP + TRRD + 2);

    sched_op_e        op;
    logic             fire;
    logic             auto_pre;
    logic             is_act;
    logic             is_rd;
    logic             is_wr;
    logic             is_pre;
    logic [NBANK-1:0] bank_open;
    logic [NBANK-1:0] bank_pre_ok;
    logic [NBANK-1:0] bank_act_ok;
    logic             rd_ok;
    logic             wr_ok;
    logic             rrd_ok;

    assign op       = sched_op_e'(req_op);
    assign auto_pre = req_addr[AP_BIT];

    // Legality of the presented request from state alone.
    always_comb begin
        case (op)
            OP_ACT:  req_ready = bank_act_ok[req_bank] & rrd_ok;
            OP_RD:   req_ready = bank_open[req_bank] & rd_ok;
            OP_WR:   req_ready = bank_open[req_bank] & wr_ok;
            default: req_ready = ~bank_open[req_bank] | bank_pre_ok[req_bank];
        endcase
    end

    // Decode the accepted request kind.
    always_comb begin
        fire   = req_valid & req_ready;
        is_act = fire & (op == OP_ACT);
        is_rd  = fire & (op == OP_RD);
        is_wr  = fire & (op == OP_WR);
        is_pre = fire & (op == OP_PRE);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NBANK; gi++) begin : g_bank
            logic hit;
            assign hit = (req_bank == BA_W'(gi));

            sched_bank_timer #(
                .TW(TW), .RD2PRE(RD2PRE), .WR2PRE(WR2PRE), .TRP(TRP)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .do_act(is_act & hit), .do_rd(is_rd & hit),
                .do_wr(is_wr & hit), .do_pre(is_pre & hit),
                .auto_pre(auto_pre),
                .is_open(bank_open[gi]), .pre_ok(bank_pre_ok[gi]),
                .act_ok(bank_act_ok[gi])
            );
        end
    endgenerate

    sched_bus_gap #(
        .TW(TW), .CCD(CCD), .RD2WR(RD2WR), .WR2RD(WR2RD), .TRRD(TRRD)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .is_act(is_act), .is_rd(is_rd),
        .is_wr(is_wr), .rd_ok(rd_ok), .wr_ok(wr_ok), .rrd_ok(rrd_ok)
    );

    sched_cmd_enc #(.BA_W(BA_W), .AW(AW)) u_enc (
        .clk(clk), .rst_n(rst_n), .fire(fire), .op(op),
        .bank(req_bank), .addr(req_addr),
        .cs_n(ddr_cs_n), .ras_n(ddr_ras_n), .cas_n(ddr_cas_n),
        .we_n(ddr_we_n), .ba(ddr_ba), .a(ddr_addr)
    );

    // R12: without valid, the pins show deselect on the next clock.
    a_r12_no_issue_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ddr_cs_n);
    // R3: a column command on the pins always follows an open of that bank.
    a_r3_read_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> bank_open[req_bank]);

endmodule

// File: tb/ddr2_cmd_sched_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pin states, a monitor
// compares them on the falling edge after they are due.
module ddr2_cmd_sched_tb_top;

    localparam int OP_ACT = 0;
    localparam int OP_RD  = 1;
    localparam int OP_WR  = 2;
    localparam int OP_PRE = 3;

    localparam int G_RD2PRE = 3;
    localparam int G_WR2PRE = 8;
    localparam int G_TRP    = 3;
    localparam int G_RDAP   = 6;
    localparam int G_WRAP   = 11;
    localparam int G_CCD    = 2;
    localparam int G_RD2WR  = 4;
    localparam int G_WR2RD  = 6;
    localparam int G_RRD    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [2:0]  req_bank = 3'd0;
    logic [13:0] req_addr = 14'd0;
    logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0]  ddr_ba;
    logic [13:0] ddr_addr;

    typedef struct {
        int          cyc;
        logic [3:0]  pins;
        logic [2:0]  ba;
        logic [13:0] a;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    ddr2_cmd_sched dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
        .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pin image {cs,ras,cas,we} per request code (R2).
    function automatic logic [3:0] pins_of(input int op);
        case (op)
            OP_ACT:  return 4'b0011;
            OP_RD:   return 4'b0101;
            OP_WR:   return 4'b0100;
            default: return 4'b0010;
        endcase
    endfunction

    // Present a request at a falling edge, wait for ready, record acceptance edge.
    task automatic issue(input int op, input int bank, input logic [13:0] addr,
                         output int acc);
        exp_t e;
        req_op = 2'(op); req_bank = 3'(bank); req_addr = addr; req_valid = 1'b1;
        #0.1;
        while (!req_ready) begin
            @(negedge clk);
            #0.1;
        end
        acc    = cyc + 1;
        e.cyc  = acc;
        e.pins = pins_of(op);
        e.ba   = 3'(bank);
        e.a    = (op == OP_PRE) ? 14'd0 : addr;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Look at ready; a stall is held with valid high for two clocks.
    task automatic probe(input int op, input int bank, input bit exp_rdy, input string req);
        req_op = 2'(op); req_bank = 3'(bank); req_addr = 14'd0;
        req_valid = exp_rdy ? 1'b0 : 1'b1;
        #0.1;
        check(req_ready == exp_rdy, req, req_ready, exp_rdy);
        @(negedge clk);
        if (!exp_rdy) begin
            check(req_ready == 1'b0, req, req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor: every selected cycle must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done && !ddr_cs_n) begin
            if (q.size() == 0) begin
                check(1'b0, "R12 R3 unexpected command", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == e.pins,
                      "R2 strobes", {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, e.pins);
                check(ddr_ba == e.ba && ddr_addr == e.a, "R2 bank/addr",
                      {ddr_ba, ddr_addr}, {e.ba, e.a});
                check(cyc == e.cyc + 0, "R2 one-cycle latency", cyc, e.cyc);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int a0, a1, a2, a3, a4;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'hF, "R1 pins idle",
              {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 15);
        probe(OP_ACT, 0, 1'b1, "R1 open ready");
        probe(OP_ACT, 7, 1'b1, "R1 open ready bank7");
        probe(OP_RD, 0, 1'b0, "R1 read stalled");
        probe(OP_WR, 3, 1'b0, "R1 write stalled");

        // R12: valid low issues nothing
        req_op = 2'(OP_ACT); req_bank = 3'd2; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(ddr_cs_n == 1'b1, "R12 no issue without valid", ddr_cs_n, 1);

        // R8, R4, R6, R10
        issue(OP_ACT, 0, 14'h1234, a0);
        issue(OP_RD, 0, 14'h0008, a1);
        check(a1 - a0 == 1, "R8 read after open", a1 - a0, 1);
        issue(OP_PRE, 0, 14'h3FFF, a2);
        check(a2 - a1 == G_RD2PRE, "R4 read to close", a2 - a1, G_RD2PRE);
        issue(OP_ACT, 0, 14'h0ABC, a3);
        check(a3 - a2 == G_TRP, "R6 close to open", a3 - a2, G_TRP);
        issue(OP_ACT, 1, 14'h0111, a4);
        check(a4 - a3 == G_RRD, "R10 open to open", a4 - a3, G_RRD);

        // R3: state-based stalls
        probe(OP_ACT, 0, 1'b0, "R3 open on open bank");
        probe(OP_RD, 2, 1'b0, "R3 read on closed bank");

        // R5
        issue(OP_WR, 1, 14'h0010, a0);
        issue(OP_PRE, 1, 14'h0000, a1);
        check(a1 - a0 == G_WR2PRE, "R5 write to close", a1 - a0, G_WR2PRE);

        // R9: column spacing
        issue(OP_RD, 0, 14'h0020, a0);
        issue(OP_RD, 0, 14'h0024, a1);
        check(a1 - a0 == G_CCD, "R9 read to read", a1 - a0, G_CCD);
        issue(OP_WR, 0, 14'h0028, a2);
        check(a2 - a1 == G_RD2WR, "R9 read to write", a2 - a1, G_RD2WR);
        issue(OP_RD, 0, 14'h002C, a3);
        check(a3 - a2 == G_WR2RD, "R9 write to read", a3 - a2, G_WR2RD);
        issue(OP_WR, 0, 14'h0030, a0);
        issue(OP_WR, 0, 14'h0034, a1);
        check(a1 - a0 == G_CCD, "R9 write to write", a1 - a0, G_CCD);

        // R7: auto-close on read and write
        issue(OP_ACT, 4, 14'h0444, a0);
        issue(OP_RD, 4, 14'h0400, a1);
        probe(OP_RD, 4, 1'b0, "R7 read after auto-close");
        issue(OP_ACT, 4, 14'h0445, a2);
        check(a2 - a1 == G_RDAP, "R7 read auto-close to open", a2 - a1, G_RDAP);
        issue(OP_ACT, 5, 14'h0555, a0);
        issue(OP_WR, 5, 14'h0404, a1);
        issue(OP_ACT, 5, 14'h0556, a2);
        check(a2 - a1 == G_WRAP, "R7 write auto-close to open", a2 - a1, G_WRAP);

        // R11: close of a closed bank
        probe(OP_PRE, 6, 1'b1, "R11 close closed bank ready");
        issue(OP_PRE, 6, 14'h0000, a0);
        probe(OP_RD, 6, 1'b0, "R11 bank stays closed");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 all expected commands seen", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule